// File: doc/BRIEF.md
# Paged Indirect Register Bridge

This block sits behind a 16-bit management register port that has single-cycle write and read strobes and a 5-bit register number. A page register chooses which register set answers. One page value opens a window of bridge registers. Through that window, a management agent can reach a 32-bit-address, 32-bit-data internal bus, even though every register is only 16 bits wide.

Each 32-bit quantity is split into an upper and a lower 16-bit half. Write and read accesses keep separate address registers. A bus write is committed when the lower data half is written. A bus read is launched when the lower read address half is written, and the returned word is held for readback. In auto-increment mode, a stream of data half pairs fills consecutive words without rewriting the address. This makes bulk loading of an internal memory cheap in management transactions.

The internal bus master is minimal. The block drives an address, write data, a write strobe and a read strobe. It expects read data in the same cycle as the read strobe.

Top module: `paged_reg_bridge`

## Requirements
- R1: After reset the page register reads 0x0000, the mode register reads 0x0000 (fixed-address mode), and neither bus strobe is active.
- R2: Register 0x1F is the page register. It can be written and read back from any page. The value 0x0004 selects the bridge page.
- R3: Registers 0x10 to 0x18 respond only while the page register holds 0x0004. With any other page value they read as zero, writes to them change no state, and they cause no bus strobe.
- R4: On the bridge page, register numbers outside 0x10 to 0x18 and other than 0x1F read as zero, and writes to them have no effect.
- R5: Register 0x10 keeps only bit 15. Bit 15 set selects auto-increment and bit 15 clear selects fixed address. Readback shows bit 15 with all other bits zero.
- R6: Registers 0x11/0x12 (write address upper/lower), 0x13/0x14 (write data upper/lower) and 0x15/0x16 (read address upper/lower) read back the last value written.
- R7: Writing 0x14 produces exactly one bus_wr pulse in the following cycle. In that pulse bus_addr is {0x11,0x12} and bus_wdata is {0x13, value written to 0x14}.
- R8: In fixed mode, the write address is unchanged after a commit. In auto-increment mode, it advances by 4 after each commit, with carry from the lower half into the upper half. The new address is visible in 0x11/0x12 and is used by the next commit.
- R9: Writing 0x16 produces exactly one bus_rd pulse in the following cycle with bus_addr equal to {0x15,0x16}. From the cycle after that pulse, 0x17 returns the upper half and 0x18 returns the lower half of the returned word.
- R10: The captured read word does not change until the next launch. Writing 0x15 alone, reading 0x17/0x18, or performing bus writes leaves the captured word unchanged. The read address is never auto-incremented.
- R11: bus_wr and bus_rd are never active in the same cycle. mgmt_rdata is zero whenever mgmt_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mgmt_wr | input | 1 | Management register write strobe |
| mgmt_rd | input | 1 | Management register read strobe |
| mgmt_addr | input | 5 | Management register number |
| mgmt_wdata | input | 16 | Management write data |
| mgmt_rdata | output | 16 | Management read data, valid while mgmt_rd is high |
| bus_addr | output | 32 | Internal bus byte address |
| bus_wdata | output | 32 | Internal bus write data |
| bus_wr | output | 1 | Internal bus write strobe, one cycle per commit |
| bus_rd | output | 1 | Internal bus read strobe, one cycle per launch |
| bus_rdata | input | 32 | Internal bus read data, sampled while bus_rd is high |

## Verification
Several properties are checked in every cycle:
- The two bus strobes never overlap.
- No strobe follows a management write made while the bridge page is closed.
- Every commit leaves the write address either unchanged or advanced by exactly one word, depending on the mode that was in force.
- The captured read word holds still except in a read-strobe cycle.
- At most one bridge register is selected per write.

Other behaviour can only be shown by the directed scenarios. These cover:
- the actual bus addresses and data driven for a given register sequence;
- correct halves returned on readback;
- carry across the 16-bit address boundary during a burst;
- isolation of other page values and unmapped register numbers;
- the pulse counts per commit and per launch, checked against a behavioural memory.

// File: rtl/pib_pkg.sv
// Package: register numbers, page codes and the write-select bundle shared by
// the bridge modules. Assumes a 5-bit management register number.
package pib_pkg;
    localparam int unsigned MGMT_AW = 5;

    localparam logic [MGMT_AW-1:0] REG_MODE = 5'h10;
    localparam logic [MGMT_AW-1:0] REG_WAH  = 5'h11;
    localparam logic [MGMT_AW-1:0] REG_WAL  = 5'h12;
    localparam logic [MGMT_AW-1:0] REG_WDH  = 5'h13;
    localparam logic [MGMT_AW-1:0] REG_WDL  = 5'h14;
    localparam logic [MGMT_AW-1:0] REG_RAH  = 5'h15;
    localparam logic [MGMT_AW-1:0] REG_RAL  = 5'h16;
    localparam logic [MGMT_AW-1:0] REG_RDH  = 5'h17;
    localparam logic [MGMT_AW-1:0] REG_RDL  = 5'h18;
    localparam logic [MGMT_AW-1:0] REG_PAGE = 5'h1F;

    localparam logic [15:0] PAGE_STD    = 16'h0000;
    localparam logic [15:0] PAGE_BRIDGE = 16'h0004;

    // One write enable per writable bridge register.
    typedef struct packed {
        logic mode;
        logic wa_hi;
        logic wa_lo;
        logic wd_hi;
        logic wd_lo;
        logic ra_hi;
        logic ra_lo;
    } pib_wsel_t;
endpackage

// File: rtl/pib_decode.sv
// Write decoder: turns a management write into at most one bridge register
// enable (only while the bridge page is open) plus the page register enable.
// Assumes one management access per cycle.
module pib_decode
    import pib_pkg::*;
#(
    parameter int unsigned AW = MGMT_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic          page_open,
    output pib_wsel_t     wsel,
    output logic          page_we
);
    // Page register is decoded regardless of the current page.
    assign page_we = wr && (addr == AW'(REG_PAGE));

    // Bridge register enables, gated by the page.
    always_comb begin
        wsel = '0;
        if (wr && page_open) begin
            case (addr)
                AW'(REG_MODE): wsel.mode  = 1'b1;
                AW'(REG_WAH):  wsel.wa_hi = 1'b1;
                AW'(REG_WAL):  wsel.wa_lo = 1'b1;
                AW'(REG_WDH):  wsel.wd_hi = 1'b1;
                AW'(REG_WDL):  wsel.wd_lo = 1'b1;
                AW'(REG_RAH):  wsel.ra_hi = 1'b1;
                AW'(REG_RAL):  wsel.ra_lo = 1'b1;
                default: ;
            endcase
        end
    end

    assert_single_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wsel) && !(page_we && (wsel != '0)));
endmodule

// File: rtl/pib_wr_chan.sv
// Write channel: holds mode, write address and upper data half; commits one
// bus write the cycle after the lower data half is written, then advances
// the address by STEP bytes when auto-increment is on.
// Assumes BUS_W == 2*REG_W.
module pib_wr_chan
    import pib_pkg::*;
#(
    parameter int unsigned REG_W = 16,
    parameter int unsigned BUS_W = 32,
    parameter int unsigned STEP  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pib_wsel_t        wsel,
    input  logic [REG_W-1:0] wdata,
    output logic             incr_mode,
    output logic [BUS_W-1:0] wr_addr,
    output logic [REG_W-1:0] wd_hi,
    output logic             bus_wr,
    output logic [BUS_W-1:0] bus_waddr,
    output logic [BUS_W-1:0] bus_wdata
);
    localparam int unsigned HALF = BUS_W / 2;

    // Mode bit: only the top bit of the written word is kept.
    always_ff @(posedge clk) begin
        if (!rst_n)         incr_mode <= 1'b0;
        else if (wsel.mode) incr_mode <= wdata[REG_W-1];
    end

    // Write address: half loads, or post-commit increment.
    always_ff @(posedge clk) begin
        if (!rst_n)               wr_addr <= '0;
        else if (wsel.wa_hi)      wr_addr[BUS_W-1:HALF] <= wdata;
        else if (wsel.wa_lo)      wr_addr[HALF-1:0] <= wdata;
        else if (wsel.wd_lo && incr_mode) wr_addr <= wr_addr + BUS_W'(STEP);
    end

    // Upper data half staging register.
    always_ff @(posedge clk) begin
        if (!rst_n)          wd_hi <= '0;
        else if (wsel.wd_hi) wd_hi <= wdata;
    end

    // Commit: strobe, address and word for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_wr    <= 1'b0;
            bus_waddr <= '0;
            bus_wdata <= '0;
        end else begin
            bus_wr <= wsel.wd_lo;
            if (wsel.wd_lo) begin
                bus_waddr <= wr_addr;
                bus_wdata <= {wd_hi, wdata};
            end
        end
    end

    assert_incr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && $past(incr_mode)) |-> (wr_addr == bus_waddr + BUS_W'(STEP)));
    assert_fixed_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !$past(incr_mode)) |-> (wr_addr == bus_waddr));
endmodule

// File: rtl/pib_rd_chan.sv
// Read channel: holds the read address, launches one bus read the cycle
// after the lower address half is written and captures the returned word.
// Assumes read data is valid in the same cycle as the read strobe.
module pib_rd_chan
    import pib_pkg::*;
#(
    parameter int unsigned REG_W = 16,
    parameter int unsigned BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pib_wsel_t        wsel,
    input  logic [REG_W-1:0] wdata,
    input  logic [BUS_W-1:0] bus_rdata,
    output logic [BUS_W-1:0] rd_addr,
    output logic [BUS_W-1:0] rd_word,
    output logic             bus_rd
);
    localparam int unsigned HALF = BUS_W / 2;

    // Read address half loads.
    always_ff @(posedge clk) begin
        if (!rst_n)          rd_addr <= '0;
        else if (wsel.ra_hi) rd_addr[BUS_W-1:HALF] <= wdata;
        else if (wsel.ra_lo) rd_addr[HALF-1:0] <= wdata;
    end

    // Launch strobe, one cycle after the lower half write.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rd <= 1'b0;
        else        bus_rd <= wsel.ra_lo;
    end

    // Capture of the returned word.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_word <= '0;
        else if (bus_rd) rd_word <= bus_rdata;
    end

    assert_word_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(rd_word));
endmodule

// File: rtl/paged_reg_bridge.sv
// Top: page register, readback multiplexer and bus address selection around
// the decoder and the two channels. Assumes one management access per cycle;
// bus write and read addresses share one bus_addr output.
module paged_reg_bridge
    import pib_pkg::*;
#(
    parameter int unsigned REG_W = 16,
    parameter int unsigned BUS_W = 2 * REG_W,
    parameter int unsigned STEP  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mgmt_wr,
    input  logic               mgmt_rd,
    input  logic [MGMT_AW-1:0] mgmt_addr,
    input  logic [REG_W-1:0]   mgmt_wdata,
    output logic [REG_W-1:0]   mgmt_rdata,
    output logic [BUS_W-1:0]   bus_addr,
    output logic [BUS_W-1:0]   bus_wdata,
    output logic               bus_wr,
    output logic               bus_rd,
    input  logic [BUS_W-1:0]   bus_rdata
);
    localparam int unsigned HALF = BUS_W / 2;

    logic [REG_W-1:0] page_q;
    logic             page_open;
    logic             page_we;
    pib_wsel_t        wsel;
    logic             incr_mode;
    logic [BUS_W-1:0] wr_addr, bus_waddr, rd_addr, rd_word;
    logic [REG_W-1:0] wd_hi;

    // Page register, reachable from every page.
    always_ff @(posedge clk) begin
        if (!rst_n)       page_q <= REG_W'(PAGE_STD);
        else if (page_we) page_q <= mgmt_wdata;
    end

    assign page_open = (page_q == REG_W'(PAGE_BRIDGE));

    pib_decode #(.AW(MGMT_AW)) u_dec (
        .clk(clk), .rst_n(rst_n), .wr(mgmt_wr), .addr(mgmt_addr),
        .page_open(page_open), .wsel(wsel), .page_we(page_we)
    );

    pib_wr_chan #(.REG_W(REG_W), .BUS_W(BUS_W), .STEP(STEP)) u_wr (
        .clk(clk), .rst_n(rst_n), .wsel(wsel), .wdata(mgmt_wdata),
        .incr_mode(incr_mode), .wr_addr(wr_addr), .wd_hi(wd_hi),
        .bus_wr(bus_wr), .bus_waddr(bus_waddr), .bus_wdata(bus_wdata)
    );

    pib_rd_chan #(.REG_W(REG_W), .BUS_W(BUS_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .wsel(wsel), .wdata(mgmt_wdata),
        .bus_rdata(bus_rdata), .rd_addr(rd_addr), .rd_word(rd_word),
        .bus_rd(bus_rd)
    );

    // Shared bus address: write address during a commit, else read address.
    assign bus_addr = bus_wr ? bus_waddr : rd_addr;

    // Readback multiplexer; zero when not reading or not mapped.
    always_comb begin
        mgmt_rdata = '0;
        if (mgmt_rd) begin
            if (mgmt_addr == REG_PAGE) begin
                mgmt_rdata = page_q;
            end else if (page_open) begin
                case (mgmt_addr)
                    REG_MODE: mgmt_rdata = {incr_mode, {(REG_W-1){1'b0}}};
                    REG_WAH:  mgmt_rdata = wr_addr[BUS_W-1:HALF];
                    REG_WAL:  mgmt_rdata = wr_addr[HALF-1:0];
                    REG_WDH:  mgmt_rdata = wd_hi;
                    REG_WDL:  mgmt_rdata = bus_wdata[HALF-1:0];
                    REG_RAH:  mgmt_rdata = rd_addr[BUS_W-1:HALF];
                    REG_RAL:  mgmt_rdata = rd_addr[HALF-1:0];
                    REG_RDH:  mgmt_rdata = rd_word[BUS_W-1:HALF];
                    REG_RDL:  mgmt_rdata = rd_word[HALF-1:0];
                    default:  mgmt_rdata = '0;
                endcase
            end
        end
    end

    assert_strobes_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));
    assert_closed_page_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_wr && !page_open) |=> (!bus_wr && !bus_rd));
endmodule

// File: tb/tb_paged_reg_bridge.sv
`timescale 1ns/1ps
module tb_paged_reg_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_wr = 1'b0, m_rd = 1'b0;
    logic [4:0]  m_addr = '0;
    logic [15:0] m_wdata = '0;
    logic [15:0] mgmt_rdata;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic        bus_wr, bus_rd;
    logic [31:0] mem [0:63];
    int checks = 0, errors = 0;
    int wr_pulses = 0, rd_pulses = 0, overlap = 0;

    always #4 clk = ~clk;

    paged_reg_bridge dut (
        .clk(clk), .rst_n(rst_n), .mgmt_wr(m_wr), .mgmt_rd(m_rd),
        .mgmt_addr(m_addr), .mgmt_wdata(m_wdata), .mgmt_rdata(mgmt_rdata),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata)
    );

    // Behavioural memory, word indexed.
    always @(posedge clk) if (bus_wr) mem[bus_addr[7:2]] <= bus_wdata;
    assign bus_rdata = mem[bus_addr[7:2]];

    // Strobe monitor, sampled away from the edge.
    always @(negedge clk) begin
        if (rst_n && bus_wr) wr_pulses++;
        if (rst_n && bus_rd) rd_pulses++;
        if (bus_wr && bus_rd) overlap++;
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic mwr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk); m_wr = 1'b1; m_addr = a; m_wdata = d;
        @(negedge clk); m_wr = 1'b0;
    endtask

    task automatic mrd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk); m_rd = 1'b1; m_addr = a;
        #1 d = mgmt_rdata;
        @(negedge clk); m_rd = 1'b0;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        check("R1", "bus_wr in reset", {31'b0, bus_wr}, 32'h0);
        check("R1", "bus_rd in reset", {31'b0, bus_rd}, 32'h0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mrd(5'h1F, v); check("R1", "page after reset", {16'h0, v}, 32'h0);
        mwr(5'h1F, 16'h0004);
        mrd(5'h10, v); check("R1", "mode after reset", {16'h0, v}, 32'h0);
    endtask

    task automatic t_page;
        logic [15:0] v;
        mrd(5'h1F, v); check("R2", "page read on bridge page", {16'h0, v}, 32'h4);
        mwr(5'h1F, 16'h0000);
        mrd(5'h1F, v); check("R2", "page read on standard page", {16'h0, v}, 32'h0);
    endtask

    task automatic t_closed_page;
        logic [15:0] v;
        int w0, r0;
        w0 = wr_pulses; r0 = rd_pulses;
        mwr(5'h11, 16'hAAAA);
        mwr(5'h14, 16'h1234);
        mwr(5'h16, 16'h0008);
        mrd(5'h11, v); check("R3", "bridge reg on standard page", {16'h0, v}, 32'h0);
        mwr(5'h1F, 16'h0005);
        mwr(5'h12, 16'h5555);
        mrd(5'h1F, v); check("R3", "odd page value held", {16'h0, v}, 32'h5);
        mrd(5'h12, v); check("R3", "bridge reg on page 5", {16'h0, v}, 32'h0);
        @(negedge clk);
        check("R3", "no strobes while closed", wr_pulses + rd_pulses, w0 + r0);
        mwr(5'h1F, 16'h0004);
        mrd(5'h11, v); check("R3", "wa_hi untouched", {16'h0, v}, 32'h0);
        mrd(5'h12, v); check("R3", "wa_lo untouched", {16'h0, v}, 32'h0);
    endtask

    task automatic t_unmapped;
        logic [15:0] v;
        mwr(5'h00, 16'hFFFF);
        mwr(5'h19, 16'hFFFF);
        mrd(5'h00, v); check("R4", "reg 0x00", {16'h0, v}, 32'h0);
        mrd(5'h19, v); check("R4", "reg 0x19", {16'h0, v}, 32'h0);
        mrd(5'h0F, v); check("R4", "reg 0x0F", {16'h0, v}, 32'h0);
        mrd(5'h10, v); check("R4", "mode untouched", {16'h0, v}, 32'h0);
    endtask

    task automatic t_mode;
        logic [15:0] v;
        mwr(5'h10, 16'hFFFF);
        mrd(5'h10, v); check("R5", "mode keeps bit 15 only", {16'h0, v}, 32'h8000);
        mwr(5'h10, 16'h7FFF);
        mrd(5'h10, v); check("R5", "mode cleared", {16'h0, v}, 32'h0);
    endtask

    task automatic t_fixed_write;
        logic [15:0] v;
        int w0;
        mwr(5'h11, 16'h0000);
        mwr(5'h12, 16'h0010);
        mwr(5'h13, 16'hDEAD);
        w0 = wr_pulses;
        mwr(5'h14, 16'hBEEF);
        check("R7", "bus_wr after commit", {31'b0, bus_wr}, 32'h1);
        check("R7", "commit address", bus_addr, 32'h0000_0010);
        check("R7", "commit data", bus_wdata, 32'hDEAD_BEEF);
        @(negedge clk);
        check("R7", "bus_wr one cycle", {31'b0, bus_wr}, 32'h0);
        check("R7", "one pulse per commit", wr_pulses - w0, 1);
        check("R7", "memory word", mem[4], 32'hDEAD_BEEF);
        mrd(5'h12, v); check("R8", "fixed address held", {16'h0, v}, 32'h0010);
        mrd(5'h13, v); check("R6", "data high readback", {16'h0, v}, 32'hDEAD);
        mrd(5'h14, v); check("R6", "data low readback", {16'h0, v}, 32'hBEEF);
        mrd(5'h11, v); check("R6", "addr high readback", {16'h0, v}, 32'h0);
    endtask

    task automatic t_incr_burst;
        logic [15:0] v;
        mwr(5'h10, 16'h8000);
        mwr(5'h11, 16'h0000);
        mwr(5'h12, 16'h0020);
        for (int i = 0; i < 3; i++) begin
            mwr(5'h13, 16'hA000 + 16'(i));
            mwr(5'h14, 16'h5000 + 16'(i));
            check("R8", "burst address", bus_addr, 32'h20 + 32'(4 * i));
            check("R7", "burst data", bus_wdata, {16'hA000 + 16'(i), 16'h5000 + 16'(i)});
        end
        mrd(5'h12, v); check("R8", "address after burst", {16'h0, v}, 32'h002C);
        mwr(5'h12, 16'hFFFC);
        mwr(5'h13, 16'h1111);
        mwr(5'h14, 16'h2222);
        check("R8", "pre-carry commit address", bus_addr, 32'h0000_FFFC);
        mrd(5'h11, v); check("R8", "carry into upper half", {16'h0, v}, 32'h0001);
        mrd(5'h12, v); check("R8", "lower half wraps", {16'h0, v}, 32'h0000);
    endtask

    task automatic t_read;
        logic [15:0] v;
        int r0;
        mwr(5'h15, 16'h0000);
        r0 = rd_pulses;
        mwr(5'h16, 16'h0024);
        check("R9", "bus_rd after launch", {31'b0, bus_rd}, 32'h1);
        check("R9", "read address on bus", bus_addr, 32'h0000_0024);
        mrd(5'h17, v); check("R9", "read high half", {16'h0, v}, 32'hA001);
        mrd(5'h18, v); check("R9", "read low half", {16'h0, v}, 32'h5001);
        check("R9", "one read pulse", rd_pulses - r0, 1);
        mrd(5'h16, v); check("R10", "read address not incremented", {16'h0, v}, 32'h0024);
    endtask

    task automatic t_read_hold;
        logic [15:0] v;
        int r0;
        r0 = rd_pulses;
        mwr(5'h15, 16'h0001);
        mrd(5'h15, v); check("R6", "read addr high readback", {16'h0, v}, 32'h0001);
        mwr(5'h13, 16'h7777);
        mwr(5'h14, 16'h8888);
        mrd(5'h17, v); check("R10", "high half held", {16'h0, v}, 32'hA001);
        mrd(5'h18, v); check("R10", "low half held", {16'h0, v}, 32'h5001);
        check("R10", "no launch without low write", rd_pulses - r0, 0);
        mwr(5'h15, 16'h0000);
        mwr(5'h16, 16'h0020);
        mrd(5'h18, v); check("R9", "relaunch low half", {16'h0, v}, 32'h5000);
    endtask

    task automatic t_misc;
        @(negedge clk); m_addr = 5'h1F; m_rd = 1'b0;
        #1 check("R11", "rdata idle zero", {16'h0, mgmt_rdata}, 32'h0);
        check("R11", "strobe overlap count", overlap, 0);
    endtask

    initial begin
        t_reset();
        t_page();
        t_closed_page();
        t_unmapped();
        t_mode();
        t_fixed_write();
        t_incr_burst();
        t_read();
        t_read_hold();
        t_misc();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements): got hang expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule